// File: doc/BRIEF.md
# Exception-Return Load Sequencer

This block takes one return-from-exception instruction, decodes it from either a single 32-bit fixed-width word or a pair of 16-bit halfwords, and executes the memory part of it. It reads the base register through a combinational read port. From the base and the addressing mode it forms a start address. It then performs two aligned word reads over a request/response memory port: the new program counter first, then the saved status word. When write-back is requested it updates the base register. The sequence ends with a one-cycle return strobe that carries both loaded words.

Before any memory access the block screens the instruction against the current privilege level, the base register index and the position inside a conditional block. Undefined and unpredictable cases are reported on their own one-cycle outputs and issue no reads. A memory error response stops the sequence with a one-cycle fault pulse and no write-back.

States: `ST_IDLE` (waiting for an instruction), `ST_READ_PC` (first read outstanding), `ST_READ_SPSR` (second read outstanding), `ST_WRITEBACK` (base update cycle) and `ST_DONE` (one-cycle outcome). Transitions: IDLE→READ_PC on a legal accepted instruction; IDLE→DONE on an accepted instruction that traps; READ_PC→READ_SPSR on a clean response; READ_PC→DONE on an error response; READ_SPSR→WRITEBACK on a clean response with write-back set; READ_SPSR→DONE on a clean response without write-back or on an error response; WRITEBACK→DONE always; DONE→IDLE always.

Top module: `exc_return_seq`

## Requirements
- R1: Fixed-width form (`instr_pair`=0) is recognised when bits 31:25 are 1111100, bit 22 is 0, bit 20 is 1 and bits 15:0 are 0x0A00; bit 24 is the pre bit, bit 23 the up bit, bit 21 the write-back bit and bits 19:16 the base index. Increment equals the up bit and the word-higher flag is set when pre equals up.
- R2: Halfword-pair form (`instr_pair`=1) carries the first halfword in bits 31:16 and the second in bits 15:0; the second must be 0xC000, the first has bit 4 set, bit 5 as write-back and bits 3:0 as base index, and bits 15:6 of 1110100000 select the decrementing variant and 1110100110 the incrementing one; word-higher is always clear.
- R3: The start address is the base when incrementing, else base minus 8, plus 4 when word-higher is set (modulo 2^32).
- R4: The program counter is read from the start address and then the status word from start plus 4; each request stays asserted with a stable address until `mem_rvalid` is seen.
- R5: With write-back set, `wb_en` pulses exactly once after the second clean response, with `wb_idx` the base index and `wb_data` the base sampled at acceptance plus 8 when incrementing or minus 8 otherwise; with write-back clear `wb_en` never rises.
- R6: A completed sequence ends with `ret_valid` high for one cycle carrying the two loaded words; at most one of return, fault and trap outcomes is shown in any cycle.
- R7: `priv_level`=2 (hypervisor) raises `undef_o` with no memory reads and no return.
- R8: `priv_level`=0 (least privileged) raises `unpred_o`, also raises `undef_o` when `cfg_user_undef` is 1, and issues no reads and no return; levels 1 and 3 execute normally.
- R9: Base index 15 raises `unpred_o`; in the halfword-pair form, `in_cond_blk`=1 with `last_in_cond_blk`=0 also raises `unpred_o`; the fixed-width form ignores the conditional-block inputs; no reads are issued for such a case.
- R10: An error response on either read pulses `fault_o` for one cycle with no write-back and no return strobe.
- R11: A word that matches neither form is ignored, and instructions offered while `busy` is high are not taken; the running sequence completes with its own operands.
- R12: `busy` is low in IDLE and high from the cycle after acceptance until the outcome cycle ends, and the block returns to IDLE the cycle after the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction offered this cycle |
| instr_word | input | 32 | Instruction bits (both halfwords for the pair form) |
| instr_pair | input | 1 | 1 = halfword-pair form, 0 = fixed-width form |
| in_cond_blk | input | 1 | Instruction sits inside a conditional block |
| last_in_cond_blk | input | 1 | Instruction is the last one of that block |
| priv_level | input | 2 | 0 least privileged, 1 and 3 normal, 2 hypervisor |
| cfg_user_undef | input | 1 | At level 0 also report undefined |
| base_rd_idx | output | 4 | Base register index for the register read port |
| base_rd_data | input | 32 | Register value for `base_rd_idx`, same cycle |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error |
| wb_en | output | 1 | Base register write strobe |
| wb_idx | output | 4 | Base register index to write |
| wb_data | output | 32 | Updated base value |
| ret_valid | output | 1 | Return strobe |
| ret_pc | output | 32 | Loaded program counter |
| ret_status | output | 32 | Loaded saved status word |
| undef_o | output | 1 | Undefined outcome pulse |
| unpred_o | output | 1 | Unpredictable outcome pulse |
| fault_o | output | 1 | Memory fault outcome pulse |

## Verification
The bench builds the block with its default 32-bit data width and drives a memory model whose response latency is switched between zero and two wait cycles. With that small setting it sweeps all eight pre/up/write-back combinations of the fixed form and all four pair-form variants against several base values, including one that wraps below zero, and computes read addresses, loaded words and write-back values arithmetically. Every privilege level, both settings of the level-0 option, base index 15, the conditional-block cases, errors on each read, an unmatched word and an instruction offered while busy are all driven in turn.

// File: rtl/exc_return_pkg.sv
package exc_return_pkg;

    localparam int REG_IDX_W = 4;
    localparam int INSTR_W   = 32;

    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] PRIV_HYP  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PC,
        ST_READ_SPSR,
        ST_WRITEBACK,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic wback;
        logic inc;
        logic word_hi;
    } addr_mode_t;

endpackage

// File: rtl/exc_return_decode.sv
module exc_return_decode
    import exc_return_pkg::*;
(
    input  logic [INSTR_W-1:0]   word,
    input  logic                 is_pair,
    output logic                 match,
    output logic [REG_IDX_W-1:0] base_idx,
    output addr_mode_t           mode
);

    logic [15:0] hw_first;
    logic [15:0] hw_second;
    logic        fixed_ok;
    logic        pair_dec_ok;
    logic        pair_inc_ok;

    assign hw_first  = word[31:16];
    assign hw_second = word[15:0];

    // R1: fixed-width pattern
    assign fixed_ok = (word[31:25] == 7'b1111100) && !word[22] && word[20]
                      && (word[15:0] == 16'h0A00);

    // R2: the two halfword-pair patterns
    assign pair_dec_ok = (hw_first[15:6] == 10'b1110100000) && hw_first[4]
                         && (hw_second == 16'hC000);
    assign pair_inc_ok = (hw_first[15:6] == 10'b1110100110) && hw_first[4]
                         && (hw_second == 16'hC000);

    always_comb begin
        if (is_pair) begin
            match        = pair_dec_ok || pair_inc_ok;
            base_idx     = hw_first[3:0];
            mode.wback   = hw_first[5];
            mode.inc     = pair_inc_ok;
            mode.word_hi = 1'b0;
        end else begin
            match        = fixed_ok;
            base_idx     = word[19:16];
            mode.wback   = word[21];
            mode.inc     = word[23];
            mode.word_hi = (word[24] == word[23]);
        end
    end

endmodule

// File: rtl/exc_return_addr.sv
module exc_return_addr
    import exc_return_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  addr_mode_t        mode,
    output logic [DATA_W-1:0] addr_first,
    output logic [DATA_W-1:0] addr_second,
    output logic [DATA_W-1:0] wb_value
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int PAIR_BYTES = 2 * WORD_BYTES;
    localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(WORD_BYTES);
    localparam logic [DATA_W-1:0] PAIR_STEP = DATA_W'(PAIR_BYTES);

    logic [DATA_W-1:0] low_edge;

    // R3: lower edge of the pair, then the word-higher shift
    assign low_edge    = mode.inc ? base : (base - PAIR_STEP);
    assign addr_first  = low_edge + (mode.word_hi ? WORD_STEP : '0);
    assign addr_second = addr_first + WORD_STEP;
    // R5: write-back depends only on direction
    assign wb_value    = mode.inc ? (base + PAIR_STEP) : (base - PAIR_STEP);

endmodule

// File: rtl/exc_return_trap.sv
module exc_return_trap
    import exc_return_pkg::*;
(
    input  logic [1:0]           priv_level,
    input  logic                 cfg_user_undef,
    input  logic [REG_IDX_W-1:0] base_idx,
    input  logic                 is_pair,
    input  logic                 in_cond_blk,
    input  logic                 last_in_cond_blk,
    output logic                 undef_hit,
    output logic                 unpred_hit
);

    localparam logic [REG_IDX_W-1:0] PC_IDX = '1;

    logic at_user;
    logic at_hyp;
    logic bad_base;
    logic bad_cond;

    assign at_user  = (priv_level == PRIV_USER);
    assign at_hyp   = (priv_level == PRIV_HYP);
    assign bad_base = (base_idx == PC_IDX);                          // R9
    assign bad_cond = is_pair && in_cond_blk && !last_in_cond_blk;    // R9

    assign undef_hit  = at_hyp || (at_user && cfg_user_undef);        // R7, R8
    assign unpred_hit = at_user || bad_base || bad_cond;              // R8, R9

endmodule

// File: rtl/exc_return_seq.sv
module exc_return_seq
    import exc_return_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr_word,
    input  logic                 instr_pair,
    input  logic                 in_cond_blk,
    input  logic                 last_in_cond_blk,
    input  logic [1:0]           priv_level,
    input  logic                 cfg_user_undef,
    output logic [REG_IDX_W-1:0] base_rd_idx,
    input  logic [DATA_W-1:0]    base_rd_data,
    output logic                 busy,
    output logic                 mem_req,
    output logic [DATA_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_rerr,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [DATA_W-1:0]    wb_data,
    output logic                 ret_valid,
    output logic [DATA_W-1:0]    ret_pc,
    output logic [DATA_W-1:0]    ret_status,
    output logic                 undef_o,
    output logic                 unpred_o,
    output logic                 fault_o
);

    localparam int WORD_BYTES = DATA_W / 8;

    seq_state_t state, state_nx;

    logic                 dec_match;
    logic [REG_IDX_W-1:0] dec_idx;
    addr_mode_t           dec_mode;
    logic                 trap_undef;
    logic                 trap_unpred;
    logic                 accept;

    logic [DATA_W-1:0]    base_q;
    logic [REG_IDX_W-1:0] idx_q;
    addr_mode_t           mode_q;
    logic [DATA_W-1:0]    pc_q;
    logic [DATA_W-1:0]    status_q;
    logic                 flag_undef;
    logic                 flag_unpred;
    logic                 flag_fault;

    logic [DATA_W-1:0]    addr_first;
    logic [DATA_W-1:0]    addr_second;
    logic [DATA_W-1:0]    wb_value;

    exc_return_decode u_decode (
        .word     (instr_word),
        .is_pair  (instr_pair),
        .match    (dec_match),
        .base_idx (dec_idx),
        .mode     (dec_mode)
    );

    exc_return_trap u_trap (
        .priv_level       (priv_level),
        .cfg_user_undef   (cfg_user_undef),
        .base_idx         (dec_idx),
        .is_pair          (instr_pair),
        .in_cond_blk      (in_cond_blk),
        .last_in_cond_blk (last_in_cond_blk),
        .undef_hit        (trap_undef),
        .unpred_hit       (trap_unpred)
    );

    exc_return_addr #(.DATA_W(DATA_W)) u_addr (
        .base        (base_q),
        .mode        (mode_q),
        .addr_first  (addr_first),
        .addr_second (addr_second),
        .wb_value    (wb_value)
    );

    assign base_rd_idx = dec_idx;
    // R11: only a matching word offered in IDLE is taken
    assign accept = (state == ST_IDLE) && instr_valid && dec_match;

    // Next-state logic (R12)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = (trap_undef || trap_unpred) ? ST_DONE : ST_READ_PC;
                end
            end
            ST_READ_PC: begin
                if (mem_rvalid) begin
                    state_nx = mem_rerr ? ST_DONE : ST_READ_SPSR;
                end
            end
            ST_READ_SPSR: begin
                if (mem_rvalid) begin
                    if (mem_rerr || !mode_q.wback) state_nx = ST_DONE;
                    else                           state_nx = ST_WRITEBACK;
                end
            end
            ST_WRITEBACK: state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            base_q      <= '0;
            idx_q       <= '0;
            mode_q      <= '0;
            pc_q        <= '0;
            status_q    <= '0;
            flag_undef  <= 1'b0;
            flag_unpred <= 1'b0;
            flag_fault  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                base_q      <= base_rd_data;
                idx_q       <= dec_idx;
                mode_q      <= dec_mode;
                flag_undef  <= trap_undef;
                flag_unpred <= trap_unpred;
                flag_fault  <= 1'b0;
            end
            if (state == ST_READ_PC && mem_rvalid) begin
                if (mem_rerr) flag_fault <= 1'b1;
                else          pc_q       <= mem_rdata;
            end
            if (state == ST_READ_SPSR && mem_rvalid) begin
                if (mem_rerr) flag_fault <= 1'b1;
                else          status_q   <= mem_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_req    = (state == ST_READ_PC) || (state == ST_READ_SPSR);
        mem_addr   = (state == ST_READ_SPSR) ? addr_second : addr_first;
        wb_en      = (state == ST_WRITEBACK);
        wb_idx     = idx_q;
        wb_data    = wb_value;
        ret_pc     = pc_q;
        ret_status = status_q;
        undef_o    = (state == ST_DONE) && flag_undef;
        unpred_o   = (state == ST_DONE) && flag_unpred;
        fault_o    = (state == ST_DONE) && flag_fault;
        ret_valid  = (state == ST_DONE) && !flag_undef && !flag_unpred && !flag_fault;
    end

    // R4: a pending request holds its address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R4: status word is fetched one word above the program counter
    p_second_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_PC && mem_rvalid && !mem_rerr)
        |=> (mem_req && mem_addr == $past(mem_addr) + DATA_W'(WORD_BYTES)));

    // R5: write-back is a single cycle followed by the return
    p_wb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (!wb_en && ret_valid));

    // R6: outcomes are mutually exclusive
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_valid, fault_o, (undef_o || unpred_o)}));

    // R7, R8, R9: a trapped instruction reaches DONE without a read
    p_trap_noread_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_o || unpred_o) |-> !$past(mem_req));

    // R10: an error response gives a fault and no write-back
    p_err_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && mem_rerr) |=> (fault_o && !wb_en));

endmodule

// File: tb/exc_return_seq_tb.sv
module exc_return_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        instr_pair = 1'b0;
    logic        in_cond_blk = 1'b0;
    logic        last_in_cond_blk = 1'b0;
    logic [1:0]  priv_level = 2'd1;
    logic        cfg_user_undef = 1'b0;
    logic [3:0]  base_rd_idx;
    logic [31:0] base_rd_data;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        ret_valid;
    logic [31:0] ret_pc;
    logic [31:0] ret_status;
    logic        undef_o;
    logic        unpred_o;
    logic        fault_o;

    logic [31:0] rf [16];
    int          lat = 0;
    int          err_at = 0;
    int          rd_n = 0;
    int          wait_cnt = 0;
    int          checks = 0;
    int          failures = 0;

    // captured run results
    int          n_reads;
    logic [31:0] rd_addr [2];
    int          wb_cnt;
    logic [3:0]  wb_i;
    logic [31:0] wb_d;
    logic        got_ret, got_fault, got_undef, got_unpred;
    logic [31:0] got_pc, got_st;

    always #5 clk = ~clk;

    assign base_rd_data = rf[base_rd_idx];

    exc_return_seq u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_pair(instr_pair), .in_cond_blk(in_cond_blk), .last_in_cond_blk(last_in_cond_blk),
        .priv_level(priv_level), .cfg_user_undef(cfg_user_undef),
        .base_rd_idx(base_rd_idx), .base_rd_data(base_rd_data), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_status(ret_status),
        .undef_o(undef_o), .unpred_o(unpred_o), .fault_o(fault_o)
    );

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    // form 0 fixed, 1 pair decrementing, 2 pair incrementing
    function automatic logic [31:0] enc(input int form, input bit p, input bit u,
                                        input bit w, input logic [3:0] rn);
        if (form == 0) return {7'b1111100, p, u, 1'b0, w, 1'b1, rn, 16'h0A00};
        if (form == 1) return {10'b1110100000, w, 1'b1, rn, 16'hC000};
        return {10'b1110100110, w, 1'b1, rn, 16'hC000};
    endfunction

    // memory model, driven shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (!mem_req || mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
            wait_cnt   = 0;
        end else if (wait_cnt >= lat) begin
            rd_n       = rd_n + 1;
            mem_rvalid = 1'b1;
            mem_rdata  = mdata(mem_addr);
            mem_rerr   = (err_at == rd_n);
        end else begin
            wait_cnt = wait_cnt + 1;
        end
    end

    task automatic chk(input string tag, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // offer one instruction and collect what happens until the outcome cycle
    task automatic run(input logic [31:0] w, input bit pair, input bit ic, input bit lc,
                       input logic [1:0] pv, input bit cfg, input bit hold,
                       input logic [31:0] w_alt);
        bit done = 0;
        n_reads = 0; wb_cnt = 0; wb_i = '0; wb_d = '0;
        got_ret = 0; got_fault = 0; got_undef = 0; got_unpred = 0;
        got_pc = '0; got_st = '0; rd_n = 0;
        @(negedge clk);
        instr_word = w; instr_pair = pair; in_cond_blk = ic; last_in_cond_blk = lc;
        priv_level = pv; cfg_user_undef = cfg; instr_valid = 1'b1;
        for (int c = 0; c < 60 && !done; c++) begin
            @(negedge clk);
            if (hold) instr_word = w_alt;
            else      instr_valid = 1'b0;
            if (mem_req && mem_rvalid) begin
                if (n_reads < 2) rd_addr[n_reads] = mem_addr;
                n_reads++;
            end
            if (wb_en) begin
                wb_cnt++; wb_i = wb_idx; wb_d = wb_data;
            end
            if (ret_valid || fault_o || undef_o || unpred_o) begin
                got_ret = ret_valid; got_fault = fault_o;
                got_undef = undef_o; got_unpred = unpred_o;
                got_pc = ret_pc; got_st = ret_status;
                done = 1;
            end
        end
        chk("watchdog R12", done, 32'(done), 32'd1);
        instr_valid = 1'b0;
        @(negedge clk);
        chk("R12 idle after outcome", !busy, 32'(busy), 32'd0);
    endtask

    task automatic t_normal(input int form, input bit p, input bit u, input bit w,
                            input logic [3:0] rn, input logic [31:0] base,
                            input bit ic, input bit lc, input logic [1:0] pv);
        bit inc, wh;
        logic [31:0] a0, a1, wbv;
        rf[rn] = base;
        inc = (form == 0) ? u : (form == 2);
        wh  = (form == 0) ? (p == u) : 1'b0;
        a0  = (inc ? base : base - 32'd8) + (wh ? 32'd4 : 32'd0);
        a1  = a0 + 32'd4;
        wbv = inc ? base + 32'd8 : base - 32'd8;
        run(enc(form, p, u, w, rn), form != 0, ic, lc, pv, 1'b0, 1'b0, '0);
        chk(form == 0 ? "R1 decode reads" : "R2 decode reads", n_reads == 2, n_reads, 2);
        chk("R3 start address", rd_addr[0] == a0, rd_addr[0], a0);
        chk("R4 second address", rd_addr[1] == a1, rd_addr[1], a1);
        chk("R6 return strobe", got_ret && !got_fault && !got_undef && !got_unpred,
            {got_ret, got_fault, got_undef, got_unpred}, 4'b1000);
        chk("R6 pc value", got_pc == mdata(a0), got_pc, mdata(a0));
        chk("R6 status value", got_st == mdata(a1), got_st, mdata(a1));
        chk("R5 writeback count", wb_cnt == int'(w), wb_cnt, 32'(w));
        if (w) begin
            chk("R5 writeback value", wb_d == wbv, wb_d, wbv);
            chk("R5 writeback index", wb_i == rn, wb_i, rn);
        end
    endtask

    task automatic t_trap(input string tag, input int form, input logic [3:0] rn,
                          input logic [1:0] pv, input bit cfg, input bit ic, input bit lc,
                          input bit e_undef, input bit e_unpred);
        rf[rn] = 32'h0000_2000;
        run(enc(form, 1'b0, 1'b1, 1'b1, rn), form != 0, ic, lc, pv, cfg, 1'b0, '0);
        chk({tag, " no reads"}, n_reads == 0, n_reads, 0);
        chk({tag, " flags"}, got_undef == e_undef && got_unpred == e_unpred && !got_ret,
            {got_ret, got_undef, got_unpred}, {1'b0, e_undef, e_unpred});
        chk({tag, " no writeback"}, wb_cnt == 0, wb_cnt, 0);
    endtask

    task automatic t_fault(input int which);
        rf[3] = 32'h0000_0800;
        err_at = which;
        run(enc(0, 1'b0, 1'b1, 1'b1, 4'd3), 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, '0);
        err_at = 0;
        chk("R10 fault pulse", got_fault && !got_ret, {got_fault, got_ret}, 2'b10);
        chk("R10 reads before stop", n_reads == which, n_reads, which);
        chk("R10 no writeback", wb_cnt == 0, wb_cnt, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R12 actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'(i) * 32'h100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset idle", !busy && !mem_req && !wb_en && !ret_valid,
            {busy, mem_req, wb_en, ret_valid}, 4'b0000);
        chk("R6 reset no outcome", !undef_o && !unpred_o && !fault_o,
            {undef_o, unpred_o, fault_o}, 3'b000);

        // R1, R3, R4, R5, R6: fixed form, every addressing mode
        for (int l = 0; l < 3; l += 2) begin
            lat = l;
            for (int m = 0; m < 8; m++) begin
                t_normal(0, m[2], m[1], m[0], 4'(m + 1), 32'h0000_1000, 1'b0, 1'b0, 2'd1);
                t_normal(0, m[2], m[1], m[0], 4'(m + 4), 32'h0000_0004, 1'b0, 1'b0, 2'd3);
                t_normal(0, m[2], m[1], m[0], 4'(14 - m), 32'hFFFF_FFF8, 1'b0, 1'b0, 2'd1);
            end
            // R2: both pair variants, with and without write-back
            for (int f = 1; f < 3; f++) begin
                t_normal(f, 1'b0, 1'b0, 1'b0, 4'd2, 32'h0000_3000, 1'b0, 1'b0, 2'd1);
                t_normal(f, 1'b0, 1'b0, 1'b1, 4'd13, 32'h8000_0000, 1'b0, 1'b0, 2'd1);
            end
        end
        lat = 1;

        // R9: conditional block cases that must still run
        t_normal(2, 1'b0, 1'b0, 1'b1, 4'd5, 32'h0000_4000, 1'b1, 1'b1, 2'd1);
        t_normal(0, 1'b0, 1'b1, 1'b1, 4'd5, 32'h0000_4000, 1'b1, 1'b0, 2'd1);

        // R7, R8, R9: trapping cases
        t_trap("R7 hyp undef", 0, 4'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        t_trap("R7 hyp undef pair", 2, 4'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        t_trap("R8 user nop", 0, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        t_trap("R8 user undef", 0, 4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        t_trap("R9 base 15", 0, 4'd15, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        t_trap("R9 base 15 pair", 1, 4'd15, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        t_trap("R9 cond not last", 1, 4'd6, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);

        // R10: error on first and on second read
        t_fault(1);
        t_fault(2);

        // R11: unmatched word is ignored
        @(negedge clk);
        instr_word = enc(0, 1'b0, 1'b1, 1'b1, 4'd2) | 32'h0040_0000;
        instr_pair = 1'b0; priv_level = 2'd1; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R11 unmatched not taken", !busy && !mem_req, {busy, mem_req}, 2'b00);
        @(negedge clk);
        instr_word = {10'b1110100110, 1'b1, 1'b1, 4'd2, 16'hC001};
        instr_pair = 1'b1; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R11 bad second halfword ignored", !busy, 32'(busy), 32'd0);

        // R11: offer held while busy, swapped to a trapping word
        rf[7] = 32'h0000_5000;
        run(enc(0, 1'b0, 1'b1, 1'b1, 4'd7), 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1,
            enc(0, 1'b0, 1'b1, 1'b1, 4'd15));
        chk("R11 busy offer ignored", got_ret && !got_unpred, {got_ret, got_unpred}, 2'b10);
        chk("R11 first operands kept", rd_addr[0] == 32'h0000_5000, rd_addr[0], 32'h0000_5000);
        chk("R11 writeback of first", wb_d == 32'h0000_5008, wb_d, 32'h0000_5008);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule